// File: doc/BRIEF.md
# Prescaled 8-bit Interval Timer

This block counts ticks of a programmable power-of-two prescaler on the CPU clock, using an 8-bit up counter. When the count rolls from FFh to 00h the counter keeps going and latches a time-out flag. The flag drives an interrupt request until software clears it. Software sets the timer up through a byte-wide mode register. That register holds a run bit and a 3-bit rate code, and a bigger code gives a faster tick. A second register address lets software read the live count or preload it.

A single write strobe and a single read strobe share a one-bit register select and an 8-bit data bus. Software can change the rate while the timer runs. The divider is not restarted when that happens, so the new rate takes hold on the next divider phase that matches it.

Top module: `ivl_timer`

## Requirements
- R1: After reset the mode register reads 00h, the count reads 00h and `irq` is low, so the timer is stopped with the slowest rate selected.
- R2: A write with `addr`=0 stores bit 7 as the run bit and bits 6:4 as the rate code. Bits 3:0 are discarded on write and read back as 0.
- R3: While running with rate code r, the count advances once every 2^(8-r) clock cycles. The first advance lands exactly 2^(8-r) rising edges after the edge that captured the run bit, when the timer was previously stopped.
- R4: While the run bit is 0 the count holds its value, and the prescaler phase returns to its start point.
- R5: An advance from FFh gives 00h. The counter keeps advancing afterwards, and the time-out flag is set, which drives `irq` high.
- R6: The time-out flag stays set until an `irq_clr` pulse is captured. If a wrap and a clear land in the same cycle, the flag ends up set.
- R7: A write with `addr`=1 loads the count from `wdata`. When it coincides with a prescaler tick the written value wins, and no wrap is flagged in that cycle.
- R8: Rewriting the mode register while the timer is running changes the rate without resetting the prescaler phase.
- R9: `rdata` is 00h whenever `rd_en` is low. With `rd_en` high, `addr`=0 returns the mode view and `addr`=1 returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 = mode, 1 = count |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| irq_clr | input | 1 | Clears the time-out flag |
| irq | output | 1 | Interrupt request, follows the time-out flag |

## Verification
The hardest case to reach from the ports is a count preload that falls on the very cycle the prescaler fires. Close behind it is a wrap that meets a flag clear in that same cycle. Both depend on knowing the prescaler phase, which is never visible at the ports. The stimulus handles this by starting from a stopped timer, so the phase is known to be zero. It then counts edges from the enabling write to place the preload or the clear on the exact tick edge. The same phase counting is used for a mid-run rate change, placed so that a restarted divider would move the next advance by two cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SEL_MODE  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int DIV_W  = 2 ** RATE_W;
  localparam int N_RATE = 2 ** RATE_W;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [N_RATE-1:0] hit;

  always_comb begin
    if (en_i) div_d = div_q + DIV_W'(1);
    else      div_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // rate code g fires when the low DIV_W-g divider bits are all ones
  for (genvar g = 0; g < N_RATE; g++) begin : g_hit
    assign hit[g] = &div_q[DIV_W-1-g:0];
  end

  assign tick_o = en_i & hit[rate_i];

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> div_q == '0);

  // R8
  div_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> div_q == $past(div_q) + DIV_W'(1));
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [RATE_W:0]   field_i,
  output logic              run_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [DATA_W-1:0] view_o
);
  localparam int LOW_W = DATA_W - RATE_W - 1;

  logic              run_q, run_d;
  logic [RATE_W-1:0] rate_q, rate_d;

  always_comb begin
    run_d  = run_q;
    rate_d = rate_q;
    if (wr_i) begin
      run_d  = field_i[RATE_W];
      rate_d = field_i[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rate_q <= '0;
    end else begin
      run_q  <= run_d;
      rate_q <= rate_d;
    end
  end

  assign run_o  = run_q;
  assign rate_o = rate_q;
  assign view_o = {run_q, rate_q, {LOW_W{1'b0}}};

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> {run_o, rate_o} == $past(field_i));

  // R2
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({run_o, rate_o}));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             wrap;

  assign wrap = tick_i & ~load_i & (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q == '1) |=> (cnt_q == '0 && flag_q));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  // R7
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_i && !load_i && cnt_q == '1));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              irq_clr,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int CNT_W = DATA_W;

  logic              rst_s_n;
  logic              mode_wr, cnt_wr;
  logic              run;
  logic [RATE_W-1:0] rate;
  logic [DATA_W-1:0] mode_view;
  logic              tick;
  logic [CNT_W-1:0]  count;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(addr);
  assign mode_wr = wr_en & (sel == SEL_MODE);
  assign cnt_wr  = wr_en & (sel == SEL_COUNT);

  tmr_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  tmr_mode_reg #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_i    (mode_wr),
    .field_i (wdata[DATA_W-1 -: RATE_W+1]),
    .run_o   (run),
    .rate_o  (rate),
    .view_o  (mode_view)
  );

  tmr_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .en_i   (run),
    .rate_i (rate),
    .tick_o (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick_i     (tick),
    .load_i     (cnt_wr),
    .load_val_i (wdata),
    .clr_i      (irq_clr),
    .count_o    (count),
    .flag_o     (irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) rdata = (sel == SEL_COUNT) ? count : mode_view;
  end

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  rate;
    logic [15:0] n;
    logic [7:0]  pre;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 16'd10,  8'h00},
    '{3'd6, 16'd20,  8'h10},
    '{3'd5, 16'd40,  8'hFE},
    '{3'd4, 16'd64,  8'h00},
    '{3'd3, 16'd100, 8'h80},
    '{3'd2, 16'd200, 8'h00},
    '{3'd1, 16'd300, 8'hFF},
    '{3'd0, 16'd600, 8'h00},
    '{3'd0, 16'd255, 8'h00},
    '{3'd7, 16'd1,   8'hFF},
    '{3'd7, 16'd2,   8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, addr, irq_clr;
  logic [7:0] wdata, rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    irq_clr = 1'b1;
    @(posedge clk); #1;
    irq_clr = 1'b0;
  endtask

  task automatic arm(input logic [2:0] r, input logic [7:0] pre);
    wr(1'b0, 8'h00);
    clr_pulse();
    wr(1'b1, pre);
    wr(1'b0, {1'b1, r, 4'hF});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0;
    irq_clr = 1'b0; wdata = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    rd(1'b0, v); check("R1 mode", v, 8'h00);
    rd(1'b1, v); check("R1 count", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R9 idle read bus
    addr = 1'b1; #1;
    check("R9 idle", rdata, 8'h00);

    // R2 low nibble ignored
    wr(1'b0, 8'h5F);
    rd(1'b0, v); check("R2 view", v, 8'h50);
    wr(1'b0, 8'hAC);
    rd(1'b0, v); check("R2 view run", v, 8'hA0);

    // R3 R5 vector table
    for (int i = 0; i < NV; i++) begin
      int p, tot;
      arm(VECS[i].rate, VECS[i].pre);
      repeat (int'(VECS[i].n)) @(posedge clk);
      #2;
      p   = 1 << (8 - int'(VECS[i].rate));
      tot = int'(VECS[i].pre) + int'(VECS[i].n) / p;
      rd(1'b1, v);
      check($sformatf("R3 count vec%0d", i), v, tot[7:0]);
      check($sformatf("R5 irq vec%0d", i), {7'd0, irq}, {7'd0, tot >= 256});
    end

    // R4 stop holds count
    arm(3'd7, 8'h00);
    repeat (6) @(posedge clk);
    #2;
    wr(1'b0, 8'h70);
    repeat (20) @(posedge clk);
    #2;
    rd(1'b1, v); check("R4 hold", v, 8'h03);

    // R6 sticky flag, then clear
    arm(3'd7, 8'hFF);
    repeat (10) @(posedge clk);
    #2;
    check("R6 sticky", {7'd0, irq}, 8'h01);
    clr_pulse();
    check("R6 cleared", {7'd0, irq}, 8'h00);

    // R6 wrap and clear on the same edge: set wins
    arm(3'd7, 8'hFF);
    @(negedge clk);
    @(negedge clk);
    irq_clr = 1'b1;
    @(posedge clk); #1;
    irq_clr = 1'b0;
    check("R6 set wins", {7'd0, irq}, 8'h01);

    // R7 preload on a tick edge, then wrap
    arm(3'd7, 8'h00);
    clr_pulse();
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hF0);
    @(posedge clk);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R7 load wins", v, 8'hFF);
    check("R7 no flag", {7'd0, irq}, 8'h00);
    repeat (2) @(posedge clk);
    #2;
    rd(1'b1, v); check("R5 wrap", v, 8'h00);
    check("R5 flag", {7'd0, irq}, 8'h01);
    repeat (2) @(posedge clk);
    #2;
    rd(1'b1, v); check("R5 keeps counting", v, 8'h01);

    // R8 rate change keeps divider phase
    arm(3'd0, 8'h00);
    repeat (5) @(posedge clk);
    wr(1'b0, 8'hE0);
    repeat (2) @(posedge clk);
    #2;
    rd(1'b1, v); check("R8 phase kept", v, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule